// File: doc/BRIEF.md
# Serial Flash Read Command Responder

This block is the slave side of a serial flash read. It runs in clock mode 0 (clock idles low) on a select line, a serial clock and a serial data input. It answers only the plain read command, serving bytes from a small internal byte array. After select falls, the host shifts in an 8-bit opcode and then a 24-bit address. The block then streams bytes out, most significant bit first, for as long as the host keeps clocking. It steps through the array one byte at a time and wraps back to location zero after the last one. Raising select ends the transfer at any point.

The array holds 2^ADDR_BITS bytes, and only the low ADDR_BITS address bits select a location. A `busy` input stands for an internal erase, program or write cycle. A read whose address completes while `busy` is high is refused silently. The data output is a value and enable pair, `sdo` and `sdo_oe`, so the pad cell above can float the line whenever the enable is low. A simple write port loads the array before use.

Top module: `spi_read_responder`

## Requirements
- R1: Opcode and address bits are sampled on rising `sck` edges while `cs_n` is low: 8 opcode bits MSB first, then 24 address bits from bit 23 down to bit 0. The read opcode is 8'h03.
- R2: `sdo_oe` is low whenever `cs_n` is high and throughout the 32 header bits.
- R3: The first data bit is driven on the falling `sck` edge that follows the 32nd rising edge, with no dummy cycles. Each later bit changes on a falling edge, and each byte goes out MSB first.
- R4: Any start address is accepted. After each complete byte the location increases by one.
- R5: After location 2^ADDR_BITS-1 the stream continues at location 0, without limit while `cs_n` stays low.
- R6: Address bits 23 down to ADDR_BITS are ignored when the array is indexed.
- R7: `cs_n` going high ends the read at any point, including mid-byte, and drops `sdo_oe`. The next selection starts again at the opcode.
- R8: If `busy` is high at the 32nd rising edge, the read is refused and `sdo_oe` stays low for the rest of the selection. A later read with `busy` low behaves normally.
- R9: Any opcode other than 8'h03 makes the block ignore the rest of the selection, with `sdo_oe` held low.
- R10: On a rising `pl_clk` with `pl_we` high, `pl_data` is written to array location `pl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Active-low select; high resets the transfer |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| busy | input | 1 | Internal write cycle in progress |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for `sdo` |
| pl_clk | input | 1 | Preload write clock |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | ADDR_BITS | Preload location |
| pl_data | input | 8 | Preload byte |

## Verification
The bench builds the block with ADDR_BITS = 5, so the array has 32 bytes. This small size lets every start location be swept, each read running three bytes with random-looking upper address bits. The wrap from 31 to 0 is reached within a few bytes, and a 70-byte stream passes through it twice. With the small array, the refused cases (busy, a foreign opcode, a mid-byte abort) can each be checked bit by bit against a pattern computed in the bench.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int OPC_BITS = 8;
  localparam int ADR_BITS_WIRE = 24;
  localparam int HDR_BITS = OPC_BITS + ADR_BITS_WIRE;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/spi_rd_header.sv
module spi_rd_header
  import spi_rd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         sck,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic         busy,
  output logic         hdr_done,
  output logic         rd_accept,
  output logic [N-1:0] start_addr
);
  localparam logic [5:0] CNT_END = 6'(HDR_BITS);
  localparam logic [5:0] CNT_OPC = 6'(OPC_BITS);

  logic [5:0]   cnt;
  byte_t        opc;
  logic [N-1:0] adr;
  logic         busy_q;

  // Only the last N address bits survive the shift, so high bits drop out.
  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      cnt    <= '0;
      opc    <= '0;
      adr    <= '0;
      busy_q <= 1'b0;
    end else if (cnt != CNT_END) begin
      cnt <= cnt + 6'd1;
      if (cnt < CNT_OPC) opc <= {opc[6:0], mosi};
      else               adr <= {adr[N-2:0], mosi};
      if (cnt == CNT_END - 6'd1) busy_q <= busy;
    end
  end

  assign hdr_done   = (cnt == CNT_END);
  assign rd_accept  = hdr_done && (opc == RD_OPCODE) && !busy_q;
  assign start_addr = adr;
endmodule

// File: rtl/spi_rd_array.sv
module spi_rd_array
  import spi_rd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         pl_clk,
  input  logic         pl_we,
  input  logic [N-1:0] pl_addr,
  input  byte_t        pl_data,
  input  logic [N-1:0] rd_addr,
  output byte_t        rd_data
);
  localparam int DEPTH = 1 << N;

  byte_t mem [DEPTH];

  always_ff @(posedge pl_clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_rd_stream.sv
module spi_rd_stream
  import spi_rd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         sck,
  input  logic         cs_n,
  input  logic         rd_accept,
  input  logic [N-1:0] start_addr,
  input  byte_t        mem_data,
  output logic [N-1:0] mem_addr,
  output logic         load_evt,
  output logic         oe,
  output logic         sdo
);
  localparam logic [N-1:0] ONE = 1;

  function automatic logic [N-1:0] wrap_inc(input logic [N-1:0] a);
    return a + ONE;
  endfunction

  logic         active;
  byte_t        obyte;
  logic [2:0]   ocnt;
  logic [N-1:0] nxt_addr;

  assign load_evt = (!active && rd_accept) || (active && ocnt == 3'd7);
  assign mem_addr = active ? nxt_addr : start_addr;

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      active   <= 1'b0;
      obyte    <= '0;
      ocnt     <= '0;
      nxt_addr <= '0;
    end else if (load_evt) begin
      active   <= 1'b1;
      obyte    <= mem_data;
      ocnt     <= '0;
      nxt_addr <= wrap_inc(mem_addr);
    end else if (active) begin
      obyte <= {obyte[6:0], 1'b0};
      ocnt  <= ocnt + 3'd1;
    end
  end

  assign oe  = active;
  assign sdo = obyte[7];
endmodule

// File: rtl/spi_read_responder.sv
module spi_read_responder
  import spi_rd_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic                 cs_n,
  input  logic                 sck,
  input  logic                 mosi,
  input  logic                 busy,
  output logic                 sdo,
  output logic                 sdo_oe,
  input  logic                 pl_clk,
  input  logic                 pl_we,
  input  logic [ADDR_BITS-1:0] pl_addr,
  input  logic [7:0]           pl_data
);
  logic                 hdr_done;
  logic                 rd_accept;
  logic                 load_evt;
  logic [ADDR_BITS-1:0] start_addr;
  logic [ADDR_BITS-1:0] mem_addr;
  byte_t                mem_data;

  spi_rd_header #(.N(ADDR_BITS)) u_hdr (
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy),
    .hdr_done(hdr_done), .rd_accept(rd_accept), .start_addr(start_addr)
  );

  spi_rd_array #(.N(ADDR_BITS)) u_mem (
    .pl_clk(pl_clk), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .rd_addr(mem_addr), .rd_data(mem_data)
  );

  spi_rd_stream #(.N(ADDR_BITS)) u_str (
    .sck(sck), .cs_n(cs_n), .rd_accept(rd_accept), .start_addr(start_addr),
    .mem_data(mem_data), .mem_addr(mem_addr), .load_evt(load_evt),
    .oe(sdo_oe), .sdo(sdo)
  );
endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker #(
  parameter int N = 8
) (
  input logic         sck,
  input logic         cs_n,
  input logic         hdr_done,
  input logic         rd_accept,
  input logic         oe,
  input logic         load_evt,
  input logic [N-1:0] mem_addr
);
  localparam logic [N-1:0] ONE = 1;

  logic seen;
  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) seen <= 1'b0;
    else      seen <= 1'b1;
  end

  AST_HEADER_QUIET: assert property (@(negedge sck) disable iff (cs_n)
    !hdr_done |-> !oe); // R2

  AST_REFUSE_SILENT: assert property (@(negedge sck) disable iff (cs_n)
    !rd_accept |-> !oe); // R8

  AST_ADDR_STEP: assert property (@(negedge sck) disable iff (cs_n)
    (oe && load_evt) |=> (!seen || mem_addr == $past(mem_addr) + ONE)); // R4

  AST_STREAM_HOLDS: assert property (@(negedge sck) disable iff (cs_n)
    oe |=> (!seen || oe)); // R7
endmodule

bind spi_read_responder spi_rd_checker #(.N(ADDR_BITS)) u_chk (
  .sck(sck), .cs_n(cs_n), .hdr_done(hdr_done), .rd_accept(rd_accept),
  .oe(sdo_oe), .load_evt(load_evt), .mem_addr(mem_addr)
);

// File: tb/spi_read_responder_test.sv
module spi_read_responder_test;
  localparam int AB = 5;
  localparam int DEPTH = 1 << AB;

  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic clk = 1'b0, pl_we = 1'b0;
  logic [AB-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  logic [7:0] shadow [DEPTH];

  always #5 clk = ~clk;

  spi_read_responder #(.ADDR_BITS(AB)) uut (
    .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe),
    .pl_clk(clk), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) ^ (i / 4));
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One bit period: sample outputs before the rising edge, then clock.
  task automatic bitcyc(input logic b, output logic o, output logic oe);
    #2 o = sdo; oe = sdo_oe; mosi = b;
    #3 sck = 1'b1;
    #5 sck = 1'b0;
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    @(negedge clk) pl_we = 1'b1; pl_addr = AB'(a); pl_data = d;
    @(negedge clk) pl_we = 1'b0;
    shadow[a] = d;
  endtask

  // expect_on=0: refused selection, enable must stay low.
  task automatic run_read(input logic [7:0] opc, input logic [23:0] a, input logic bz,
                          input int nbytes, input bit expect_on, input string req);
    logic o, oe;
    int s;
    s = int'(a[AB-1:0]);
    cs_n = 1'b0; busy = bz; #5;
    for (int i = 0; i < 32; i++) begin
      bitcyc(i < 8 ? opc[7-i] : a[31-i], o, oe);
      check(oe === 1'b0, "R2 header quiet", {7'd0, oe}, 8'd0);
    end
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] got;
      logic [7:0] exp;
      exp = shadow[(s + k) % DEPTH];
      for (int j = 0; j < 8; j++) begin
        bitcyc(1'b0, o, oe);
        got[7-j] = o;
        if (expect_on) check(oe === 1'b1, {req, " oe"}, {7'd0, oe}, 8'd1);
        else           check(oe === 1'b0, {req, " refused"}, {7'd0, oe}, 8'd0);
      end
      if (expect_on) check(got === exp, req, got, exp);
    end
    #3 cs_n = 1'b1; busy = 1'b0; #5;
    check(sdo_oe === 1'b0, "R7 deselect", {7'd0, sdo_oe}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic o, oe;
    #1 check(sdo_oe === 1'b0, "R2 reset", {7'd0, sdo_oe}, 8'd0);
    for (int i = 0; i < DEPTH; i++) write_byte(i, pat(i)); // R10 preload
    // R1 R3 R4 R6: every start location, junk in the upper address bits
    for (int s = 0; s < DEPTH; s++)
      run_read(8'h03, {19'h5A5A5 ^ 19'(s * 977), 5'(s)}, 1'b0, 3, 1'b1, "R4 sweep R6");
    // R5: wrap from the top and a long stream through two wraps
    run_read(8'h03, 24'h00001E, 1'b0, 5, 1'b1, "R5 wrap");
    run_read(8'h03, 24'hFFFFE0, 1'b0, 70, 1'b1, "R5 long stream");
    // R10: overwrite one location, read it back, restore
    write_byte(5, 8'hA5);
    run_read(8'h03, 24'h000005, 1'b0, 1, 1'b1, "R10 preload");
    write_byte(5, pat(5));
    // R9: foreign opcode
    run_read(8'h0B, 24'h000004, 1'b0, 2, 1'b0, "R9 opcode");
    // R8: busy at address end refuses, then a normal read works
    run_read(8'h03, 24'h000007, 1'b1, 2, 1'b0, "R8 busy");
    run_read(8'h03, 24'h000007, 1'b0, 2, 1'b1, "R8 after busy");
    // R7: abort mid-byte, then a fresh read starts at the opcode
    cs_n = 1'b0; #5;
    for (int i = 0; i < 32; i++) bitcyc(i < 8 ? 1'(8'h03 >> (7 - i)) : 1'b0, o, oe);
    for (int j = 0; j < 4; j++) bitcyc(1'b0, o, oe);
    check(oe === 1'b1, "R7 streaming before abort", {7'd0, oe}, 8'd1);
    #3 cs_n = 1'b1; #1;
    check(sdo_oe === 1'b0, "R7 abort", {7'd0, sdo_oe}, 8'd0);
    #4;
    run_read(8'h03, 24'h000009, 1'b0, 2, 1'b1, "R7 restart");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule